// File: doc/BRIEF.md
# Character Dot Pattern Generator

This block scans a 16-position, one-line dot-matrix character display built from cells of five columns by eight rows. For every position and row it reads a character code from a 40-byte display RAM. Where the code calls for it, the block takes the 5-bit row pattern from a 64-entry user pattern RAM. For all other codes it uses a small built-in font stub. It then applies the cursor bar, character blinking, the display enable and a four-step brightness duty cycle. The result is one row of five dots and an anode enable per time slot.

The scan is a three-state machine. FETCH reads the display RAM at the shifted address. LOOKUP forms the row pattern and latches the display enable and brightness. DRIVE holds the row on the outputs for four quarters of QUARTER_CYC clocks each. The transitions are FETCH→LOOKUP, which is unconditional, and LOOKUP→DRIVE, which is also unconditional. DRIVE→DRIVE holds while quarters remain, and DRIVE→FETCH takes place at the end of the last quarter, when the row, and after row 7 the position, advances. A host fills both RAMs through simple write ports and sets the display controls as static levels.

Top module: `char_dot_gen`

## Requirements
- R1: During and after reset `dots` is 0, `anode_en` is 0 and `slot_live` is 0. Every display RAM byte resets to 20H, every pattern RAM row resets to 0, and the scan starts at position 0, row 0.
- R2: Rows are scanned 0..7 within each position, and positions are scanned 0..15, after which the scan wraps to position 0. Each slot spends one FETCH cycle and one LOOKUP cycle, then 4×QUARTER_CYC DRIVE cycles with `slot_live` high. The first live slot starts on the second clock edge after reset is released.
- R3: The display RAM address of position p is (p + `shift_amt`) mod 40.
- R4: A code whose bits 7..4 are all 0 takes its row from pattern RAM entry {code[2:0], row}, with code bit 3 ignored. So 00H and 08H show the same pattern. Bit 4 of the row is the leftmost dot, and a 1 lights it.
- R5: Any other code uses the font stub. Rows 0..6 give code[4:0] XOR {00, row}, and row 7 gives 00000.
- R6: With `cursor_on` set, row 7 of the cell whose address equals `cursor_addr` shows the stored row ORed with 11111.
- R7: With `blink_on` set, the cell at `cursor_addr` shows 11111 on every row while the blink phase is 1. The phase starts at 0 on reset release and toggles every BLINK_HALF clocks. A slot uses the phase present on the edge that ends its LOOKUP cycle.
- R8: `bright` values 0, 1, 2 and 3 hold `anode_en` high for the first 4, 3, 2 and 1 quarters of the DRIVE time.
- R9: With `disp_on` low, the slot shows dots 0 and never raises `anode_en`. RAM contents are kept and shown again once `disp_on` returns.
- R10: A display RAM write to an address of 40 or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| disp_on | input | 1 | Display enable |
| cursor_on | input | 1 | Cursor bar enable |
| blink_on | input | 1 | Blink enable for the cursor cell |
| bright | input | 2 | Brightness step, 0 brightest |
| shift_amt | input | 6 | Display shift offset |
| cursor_addr | input | 6 | Display RAM address of the cursor cell |
| dd_we | input | 1 | Display RAM write strobe |
| dd_addr | input | 6 | Display RAM write address |
| dd_wdata | input | 8 | Display RAM write code |
| cg_we | input | 1 | Pattern RAM write strobe |
| cg_addr | input | 6 | Pattern RAM write address {char, row} |
| cg_wdata | input | 5 | Pattern RAM write row |
| dots | output | 5 | Row dots of the live slot, bit 4 leftmost |
| anode_en | output | 1 | Anode pulse enable |
| slot_live | output | 1 | High during DRIVE |
| slot_pos | output | 4 | Position of the live slot |
| slot_row | output | 3 | Row of the live slot |

## Verification
A slot's dots, position and row are due on the first DRIVE cycle, two edges after its FETCH cycle. They are captured at the falling edge where `slot_live` first reads high. The anode count is due over the whole slot, so it is compared when `slot_live` drops. The blink phase expected in a slot comes from the bench's own count of edges since reset, taken one edge before that first DRIVE cycle. Expectations for a whole frame are queued only after the controls and RAM writes are settled and the previous frame has ended, so every queued item meets a slot that used them.

// File: rtl/cdg_pkg.sv
package cdg_pkg;

    localparam int DOT_COLS = 5;
    localparam int CELL_ROWS = 8;
    localparam int CODE_W = 8;
    localparam int CG_AW = 6;

    typedef enum logic [1:0] {
        S_FETCH  = 2'd0,
        S_LOOKUP = 2'd1,
        S_DRIVE  = 2'd2
    } scan_state_e;

    // Stub font: a fixed mix of code and row, blank bottom row.
    function automatic logic [DOT_COLS-1:0] font_stub_row(
        input logic [CODE_W-1:0] code,
        input logic [2:0]        row
    );
        if (row == 3'd7) begin
            return '0;
        end
        return code[4:0] ^ {2'b00, row};
    endfunction

endpackage

// File: rtl/cdg_disp_ram.sv
module cdg_disp_ram #(
    parameter int          DEPTH = 40,
    parameter int          AW    = 6,
    parameter int          DW    = 8,
    parameter logic [7:0]  FILL  = 8'h20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= DW'(FILL);
            end
        end else if (we && ({1'b0, waddr} < DEPTH_V)) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        if ({1'b0, raddr} < DEPTH_V) begin
            rdata = mem[raddr];
        end else begin
            rdata = DW'(FILL);
        end
    end

endmodule

// File: rtl/cdg_pattern_ram.sv
module cdg_pattern_ram #(
    parameter int AW = 6,
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/cdg_blink_timer.sv
module cdg_blink_timer #(
    parameter int HALF = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);

    localparam int BW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [BW-1:0] LAST = BW'(HALF - 1);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cdg_cell_pattern.sv
module cdg_cell_pattern
    import cdg_pkg::*;
(
    input  logic [CODE_W-1:0]   code,
    input  logic [2:0]          row,
    input  logic                is_cursor_cell,
    input  logic                cursor_on,
    input  logic                blink_on,
    input  logic                blink_phase,
    output logic [CG_AW-1:0]    cg_raddr,
    input  logic [DOT_COLS-1:0] cg_rdata,
    output logic [DOT_COLS-1:0] cell_dots
);

    logic                use_ram;
    logic [DOT_COLS-1:0] base_row;
    logic                bar_on;

    assign use_ram  = (code[7:4] == 4'h0);
    assign cg_raddr = {code[2:0], row};

    always_comb begin
        base_row = use_ram ? cg_rdata : font_stub_row(code, row);
        bar_on   = cursor_on && is_cursor_cell && (row == 3'd7);
        if (blink_on && is_cursor_cell && blink_phase) begin
            cell_dots = '1;
        end else if (bar_on) begin
            cell_dots = base_row | {DOT_COLS{1'b1}};
        end else begin
            cell_dots = base_row;
        end
    end

endmodule

// File: rtl/char_dot_gen.sv
module char_dot_gen
    import cdg_pkg::*;
#(
    parameter int POSITIONS   = 16,
    parameter int LINE_LEN    = 40,
    parameter int QUARTER_CYC = 4,
    parameter int BLINK_HALF  = 25_000_000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          disp_on,
    input  logic                          cursor_on,
    input  logic                          blink_on,
    input  logic [1:0]                    bright,
    input  logic [$clog2(LINE_LEN)-1:0]   shift_amt,
    input  logic [$clog2(LINE_LEN)-1:0]   cursor_addr,
    input  logic                          dd_we,
    input  logic [$clog2(LINE_LEN)-1:0]   dd_addr,
    input  logic [7:0]                    dd_wdata,
    input  logic                          cg_we,
    input  logic [5:0]                    cg_addr,
    input  logic [4:0]                    cg_wdata,
    output logic [4:0]                    dots,
    output logic                          anode_en,
    output logic                          slot_live,
    output logic [$clog2(POSITIONS)-1:0]  slot_pos,
    output logic [2:0]                    slot_row
);

    localparam int AW = $clog2(LINE_LEN);
    localparam int PW = $clog2(POSITIONS);
    localparam int SW = (QUARTER_CYC > 1) ? $clog2(QUARTER_CYC) : 1;
    localparam logic [AW:0]   LEN_V    = (AW+1)'(LINE_LEN);
    localparam logic [SW-1:0] SUB_LAST = SW'(QUARTER_CYC - 1);
    localparam logic [PW-1:0] POS_LAST = PW'(POSITIONS - 1);

    scan_state_e state_q, state_d;

    logic [PW-1:0]       pos_q;
    logic [2:0]          row_q;
    logic [1:0]          qidx_q;
    logic [SW-1:0]       sub_q;
    logic [CODE_W-1:0]   code_q;
    logic [AW-1:0]       addr_q;
    logic [DOT_COLS-1:0] dots_q;
    logic                on_q;
    logic [2:0]          lvl_q;

    logic [AW:0]         addr_sum;
    logic [AW:0]         addr_wrap;
    logic [AW-1:0]       rd_addr;
    logic [CODE_W-1:0]   rd_code;
    logic [CG_AW-1:0]    cg_raddr;
    logic [DOT_COLS-1:0] cg_rdata;
    logic [DOT_COLS-1:0] cell_dots;
    logic                blink_phase;
    logic                slot_done;

    // Position to display RAM address, wrapped on the line length.
    always_comb begin
        addr_sum  = (AW+1)'(pos_q) + {1'b0, shift_amt};
        addr_wrap = (addr_sum >= LEN_V) ? (addr_sum - LEN_V) : addr_sum;
        rd_addr   = addr_wrap[AW-1:0];
    end

    cdg_disp_ram #(
        .DEPTH (LINE_LEN),
        .AW    (AW),
        .DW    (CODE_W),
        .FILL  (8'h20)
    ) u_disp_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (dd_we),
        .waddr (dd_addr),
        .wdata (dd_wdata),
        .raddr (rd_addr),
        .rdata (rd_code)
    );

    cdg_pattern_ram #(
        .AW (CG_AW),
        .DW (DOT_COLS)
    ) u_pattern_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (cg_we),
        .waddr (cg_addr),
        .wdata (cg_wdata),
        .raddr (cg_raddr),
        .rdata (cg_rdata)
    );

    cdg_blink_timer #(
        .HALF (BLINK_HALF)
    ) u_blink (
        .clk   (clk),
        .rst   (rst),
        .phase (blink_phase)
    );

    cdg_cell_pattern u_cell (
        .code           (code_q),
        .row            (row_q),
        .is_cursor_cell (addr_q == cursor_addr),
        .cursor_on      (cursor_on),
        .blink_on       (blink_on),
        .blink_phase    (blink_phase),
        .cg_raddr       (cg_raddr),
        .cg_rdata       (cg_rdata),
        .cell_dots      (cell_dots)
    );

    assign slot_done = (qidx_q == 2'd3) && (sub_q == SUB_LAST);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH:  state_d = S_LOOKUP;
            S_LOOKUP: state_d = S_DRIVE;
            S_DRIVE:  state_d = slot_done ? S_FETCH : S_DRIVE;
            default:  state_d = S_FETCH;
        endcase
    end

    // State register.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= S_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Slot datapath.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            pos_q  <= '0;
            row_q  <= '0;
            qidx_q <= '0;
            sub_q  <= '0;
            code_q <= '0;
            addr_q <= '0;
            dots_q <= '0;
            on_q   <= 1'b0;
            lvl_q  <= '0;
        end else begin
            unique case (state_q)
                S_FETCH: begin
                    code_q <= rd_code;
                    addr_q <= rd_addr;
                end
                S_LOOKUP: begin
                    dots_q <= disp_on ? cell_dots : '0;
                    on_q   <= disp_on;
                    lvl_q  <= 3'd4 - {1'b0, bright};
                    qidx_q <= '0;
                    sub_q  <= '0;
                end
                S_DRIVE: begin
                    if (sub_q == SUB_LAST) begin
                        sub_q  <= '0;
                        qidx_q <= qidx_q + 2'd1;
                    end else begin
                        sub_q <= sub_q + 1'b1;
                    end
                    if (slot_done) begin
                        row_q <= row_q + 3'd1;
                        if (row_q == 3'd7) begin
                            pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
                        end
                    end
                end
                default: begin
                    code_q <= code_q;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        slot_live = (state_q == S_DRIVE);
        anode_en  = slot_live && on_q && ({1'b0, qidx_q} < lvl_q);
        dots      = slot_live ? dots_q : '0;
        slot_pos  = pos_q;
        slot_row  = row_q;
    end

    assert_addr_in_line_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_FETCH) |-> ({1'b0, rd_addr} < LEN_V))
        else $error("display address outside the line");

    assert_anode_rise_first_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(anode_en) |-> (qidx_q == 2'd0 && sub_q == '0))
        else $error("anode pulse started after the first quarter");

    assert_blank_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_LOOKUP && !disp_on) |=> (dots == '0 && !anode_en))
        else $error("display off slot not blank");

    assert_scan_advance_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(slot_live) |-> (state_q == S_FETCH && row_q == 3'($past(row_q) + 3'd1)))
        else $error("row did not advance at slot end");

endmodule

// File: tb/sim_char_dot_gen.sv
`timescale 1ns/1ps
module sim_char_dot_gen;

    localparam int QC   = 2;
    localparam int BH   = 64;
    localparam int LLEN = 40;

    logic       clk = 1'b0;
    logic       rst;
    logic       disp_on, cursor_on, blink_on;
    logic [1:0] bright;
    logic [5:0] shift_amt, cursor_addr;
    logic       dd_we;
    logic [5:0] dd_addr;
    logic [7:0] dd_wdata;
    logic       cg_we;
    logic [5:0] cg_addr;
    logic [4:0] cg_wdata;
    logic [4:0] dots;
    logic       anode_en, slot_live;
    logic [3:0] slot_pos;
    logic [2:0] slot_row;

    always #10 clk = ~clk;

    char_dot_gen #(
        .POSITIONS(16), .LINE_LEN(LLEN), .QUARTER_CYC(QC), .BLINK_HALF(BH)
    ) u0 (
        .clk(clk), .rst(rst), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .bright(bright), .shift_amt(shift_amt),
        .cursor_addr(cursor_addr), .dd_we(dd_we), .dd_addr(dd_addr),
        .dd_wdata(dd_wdata), .cg_we(cg_we), .cg_addr(cg_addr),
        .cg_wdata(cg_wdata), .dots(dots), .anode_en(anode_en),
        .slot_live(slot_live), .slot_pos(slot_pos), .slot_row(slot_row)
    );

    typedef struct packed {
        logic [3:0] pos;
        logic [2:0] row;
        logic [4:0] base;
        logic       blinkable;
        logic [3:0] anode;
    } exp_t;

    exp_t       q[$];
    logic [7:0] dd_m [LLEN];
    logic [4:0] cg_m [64];
    int         checks = 0;
    int         errors = 0;
    int         seen_lit = 0;
    int         seen_norm = 0;
    longint     ecount = 0;
    string      cur_req = "R1";

    always @(posedge clk) begin
        if (rst) ecount <= 0;
        else     ecount <= ecount + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t make_exp(input int p, input int r);
        exp_t       e;
        int         a;
        logic [7:0] c;
        logic [4:0] b;
        a = (p + int'(shift_amt)) % LLEN;
        c = dd_m[a];
        if (c[7:4] == 4'h0) b = cg_m[{c[2:0], 3'(r)}];
        else if (r == 7)    b = 5'h00;
        else                b = c[4:0] ^ 5'(r);
        if (cursor_on && a == int'(cursor_addr) && r == 7) b = 5'h1f;
        e.pos       = 4'(p);
        e.row       = 3'(r);
        e.base      = disp_on ? b : 5'h00;
        e.blinkable = disp_on && blink_on && (a == int'(cursor_addr));
        e.anode     = disp_on ? 4'((4 - int'(bright)) * QC) : 4'd0;
        return e;
    endfunction

    // Monitor: compares one queued item per finished slot.
    logic [4:0] cap_dots;
    logic [3:0] cap_pos;
    logic [2:0] cap_row;
    int         cap_phase, acnt;
    logic       prev_live = 1'b0;

    always @(negedge clk) begin
        exp_t       e;
        logic [4:0] edots;
        if (rst) begin
            prev_live = 1'b0;
        end else begin
            if (slot_live && !prev_live) begin
                cap_dots  = dots;
                cap_pos   = slot_pos;
                cap_row   = slot_row;
                cap_phase = int'(((ecount - 1) / BH) % 2);
                acnt      = 0;
            end
            if (slot_live && anode_en) acnt++;
            if (!slot_live && prev_live && q.size() > 0) begin
                e = q.pop_front();
                edots = (e.blinkable && cap_phase == 1) ? 5'h1f : e.base;
                if (e.blinkable) begin
                    if (cap_phase == 1) seen_lit++;
                    else                seen_norm++;
                end
                check(cap_pos == e.pos && cap_row == e.row, {"R2 ", cur_req},
                      "slot pos/row", int'({cap_pos, cap_row}), int'({e.pos, e.row}));
                check(cap_dots == edots, cur_req, "dots", int'(cap_dots), int'(edots));
                check(acnt == int'(e.anode), cur_req, "anode cycles", acnt, int'(e.anode));
            end
            prev_live = slot_live;
        end
    end

    task automatic wr_dd(input int a, input logic [7:0] d);
        @(negedge clk);
        dd_we = 1'b1; dd_addr = 6'(a); dd_wdata = d;
        if (a < LLEN) dd_m[a] = d;
        @(negedge clk);
        dd_we = 1'b0;
    endtask

    task automatic wr_cg(input int a, input logic [4:0] d);
        @(negedge clk);
        cg_we = 1'b1; cg_addr = 6'(a); cg_wdata = d;
        cg_m[a] = d;
        @(negedge clk);
        cg_we = 1'b0;
    endtask

    // Driver: waits for a frame boundary, then queues a full frame.
    task automatic run_frame(input string req);
        cur_req = req;
        do @(negedge clk); while (!(slot_live && slot_pos == 4'd15 && slot_row == 3'd7));
        do @(negedge clk); while (slot_live);
        @(negedge clk);
        for (int p = 0; p < 16; p++) begin
            for (int r = 0; r < 8; r++) begin
                q.push_back(make_exp(p, r));
            end
        end
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        disp_on = 1'b1; cursor_on = 1'b0; blink_on = 1'b0; bright = 2'd0;
        shift_amt = 6'd0; cursor_addr = 6'd0;
        dd_we = 1'b0; dd_addr = '0; dd_wdata = '0;
        cg_we = 1'b0; cg_addr = '0; cg_wdata = '0;
        for (int i = 0; i < LLEN; i++) dd_m[i] = 8'h20;
        for (int i = 0; i < 64; i++)   cg_m[i] = 5'h00;
        repeat (3) @(negedge clk);
        check(dots == 5'h0 && !anode_en && !slot_live, "R1", "outputs in reset",
              int'({dots, anode_en, slot_live}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!slot_live, "R2", "live after first edge", int'(slot_live), 0);
        @(negedge clk);
        check(slot_live && slot_pos == 4'd0 && slot_row == 3'd0, "R1",
              "first slot", int'({slot_live, slot_pos, slot_row}), 128);

        run_frame("R1 R5");

        for (int i = 0; i < 64; i++) wr_cg(i, 5'((i * 7 + 3) & 31));
        wr_dd(0, 8'h41); wr_dd(1, 8'h00); wr_dd(2, 8'h08); wr_dd(3, 8'h07);
        wr_dd(4, 8'h0F); wr_dd(15, 8'h7E); wr_dd(35, 8'h93); wr_dd(39, 8'h05);
        cursor_on = 1'b1; cursor_addr = 6'd3; bright = 2'd1;
        run_frame("R4 R6 R8");

        shift_amt = 6'd30; bright = 2'd2; cursor_on = 1'b0;
        blink_on = 1'b1; cursor_addr = 6'd39;
        run_frame("R3 R7");
        check(seen_lit > 0 && seen_norm > 0, "R7", "both blink phases seen",
              seen_lit * 256 + seen_norm, 1);

        shift_amt = 6'd0; bright = 2'd3; blink_on = 1'b0;
        cursor_on = 1'b1; cursor_addr = 6'd1;
        wr_dd(40, 8'h00); wr_dd(52, 8'h00); wr_dd(63, 8'h00);
        run_frame("R10 R8");

        disp_on = 1'b0;
        run_frame("R9");
        disp_on = 1'b1; bright = 2'd0; cursor_on = 1'b0;
        run_frame("R9 R4");

        finish_run();
    end

endmodule